// File: doc/BRIEF.md
# Slave Response Receiver with Busy Retry

This block runs the receive half of a single-wire, master-clocked serial transaction. Once a command frame has left the master, the block keeps the bus clock running. It samples the shared data line once per cycle and hunts for the slave's start bit. It then takes in the header, and the read data when a read was issued. It checks the trailing 4-bit CRC and signals completion with an error code.

A slave that answers busy is polled again without any help from the host. The block drives the line idle, sends a fixed short poll frame, lets the line settle, and listens again. The number of polls is bounded.

A host issues `start_i` together with the transfer direction and size, then waits for `done_o`. The error code, the slave ID and the read data stay valid from `done_o` until the next start.

Top module: `slv_rsp_rx`

## Requirements
- R1: After reset, `done_o`, `sdo_oe_o` and `line_clk_en_o` are 0, and `err_o`, `rid_o` and `rdata_o` are all zero.
- R2: The line is active low, and the logical bit is the inverse of `sdi_i`. From the cycle after `start_i` is accepted, one bit is sampled per cycle, looking for a logical 1. If 1000 samples pass without one, 20 further cycles are clocked to drain the line and `done_o` rises with `err_o`=1 (timeout), 1020 cycles after the start edge.
- R3: After the start bit, 2 ID bits and then 2 response-code bits arrive MSB first. Codes are 0 ack, 1 busy, 2 slave error and 3 slave-detected CRC error. `rid_o` returns the ID, and the ID value never changes acceptance.
- R4: On ack to a read, `size_i` selects 8 (0), 16 (1) or 32 (2 or 3) data bits. They are captured MSB first, right-aligned in `rdata_o`, with the upper bits zero. A write ack carries no data.
- R5: The expected CRC uses polynomial x^4+x+1, seed 0, and is fed MSB first with a leading 1, the ID, the code and any data bits. It is compared with the next 4 received bits. A mismatch raises `done_o` with `err_o`=5 in the cycle after the last CRC bit.
- R6: On a CRC match, 100 more cycles are clocked before `done_o` rises with `err_o`=0. Let D be the number of idle samples before the start bit and L the data length. Then `done_o` is high D+109+L cycles after the start edge.
- R7: Code 2 finishes with `err_o`=3 and code 3 finishes with `err_o`=4. In both cases this happens after 4 further cycles, D+9 cycles after the start edge.
- R8: On busy, `sdo_oe_o` is high for exactly 126 cycles. During these, `sdo_o` is high for 100 cycles, then low (start bit), then 9'h1D5 MSB first (the poll word 0x2A inverted), then high for 16 cycles. Hunting then resumes.
- R9: At most 100 polls are sent per transaction. A busy answer after the 100th poll ends the transaction with `err_o`=2 and sends no poll.
- R10: `line_clk_en_o` is high while a transaction runs and low in the `done_o` cycle. `rdata_o` and `rid_o` hold their values from `done_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one bus bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin waiting for a response (accepted when idle) |
| read_i | input | 1 | 1 = read transaction, data expected on ack |
| size_i | input | 2 | Data size: 0 byte, 1 half-word, 2/3 word |
| sdi_i | input | 1 | Data line input, active low |
| sdo_o | output | 1 | Data line drive value |
| sdo_oe_o | output | 1 | Data line drive enable |
| line_clk_en_o | output | 1 | Bus clock enable while active |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 3 | 0 ok, 1 timeout, 2 busy stuck, 3 slave error, 4 slave CRC error, 5 response CRC mismatch |
| rid_o | output | 2 | ID from the response header |
| rdata_o | output | 32 | Read data, right-aligned |

## Verification
A wrong bit counter or state shows first as a shifted `done_o` cycle. Every finishing path has an exact latency from the start edge, so one slot early or late is visible in the completion cycle. A wrong header split or data alignment corrupts the CRC, which surfaces as `err_o`=5 on otherwise clean frames. A wrong poll sequence shows on `sdo_o` within the 126-cycle drive window of the first busy answer, and a wrong retry bound shows as a poll count other than 100 before the busy-stuck code.

// File: rtl/slv_rsp_pkg.sv
package slv_rsp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HUNT, ST_HDR, ST_DATA, ST_CRC, ST_PRIME,
    ST_TAIL, ST_DRAIN, ST_PRE, ST_POLL, ST_ECHO
  } state_e;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0, ERR_TIMEOUT = 3'd1, ERR_STUCK = 3'd2,
    ERR_SLAVE = 3'd3, ERR_SCRC = 3'd4, ERR_RCRC = 3'd5
  } err_e;

  localparam logic [1:0] CODE_ACK  = 2'd0;
  localparam logic [1:0] CODE_BUSY = 2'd1;
  localparam logic [1:0] CODE_ERR  = 2'd2;
  localparam logic [1:0] CODE_CRC  = 2'd3;

  // x^4+x+1, MSB first
  function automatic logic [3:0] crc4_step(logic [3:0] c, logic b);
    logic fb;
    fb = b ^ c[3];
    return {c[2:0], 1'b0} ^ (fb ? 4'h3 : 4'h0);
  endfunction
endpackage

// File: rtl/slv_rsp_crc4.sv
module slv_rsp_crc4
  import slv_rsp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [3:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= '0;
    else if (init_i) crc_o <= crc4_step(4'h0, 1'b1); // seed with leading 1
    else if (en_i)   crc_o <= crc4_step(crc_o, bit_i);
  end
endmodule

// File: rtl/slv_rsp_shreg.sv
module slv_rsp_shreg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (en_i)  q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/slv_rsp_line_drv.sv
module slv_rsp_line_drv #(
  parameter int          POLL_LEN  = 9,
  parameter logic [15:0] POLL_WORD = 16'h002A,
  parameter int          CW        = 10
) (
  input  logic          pre_i,
  input  logic          poll_i,
  input  logic          echo_i,
  input  logic [CW-1:0] idx_i,
  output logic          sdo_o,
  output logic          oe_o
);
  localparam logic [POLL_LEN:0] FRAME = {1'b1, POLL_WORD[POLL_LEN-1:0]};

  always_comb begin
    sdo_o = 1'b1;
    if (poll_i && int'(idx_i) <= POLL_LEN)
      sdo_o = ~FRAME[POLL_LEN - int'(idx_i)];
  end

  assign oe_o = pre_i | poll_i | echo_i;
endmodule

// File: rtl/slv_rsp_rx.sv
module slv_rsp_rx
  import slv_rsp_pkg::*;
#(
  parameter int          TIMEOUT_CLKS  = 1000,
  parameter int          DRAIN_CLKS    = 20,
  parameter int          MAX_RETRY     = 100,
  parameter int          PRE_POLL_CLKS = 100,
  parameter int          ECHO_CLKS     = 16,
  parameter int          PRIME_CLKS    = 100,
  parameter int          TAIL_CLKS     = 4,
  parameter int          POLL_LEN      = 9,
  parameter logic [15:0] POLL_WORD     = 16'h002A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        read_i,
  input  logic [1:0]  size_i,
  input  logic        sdi_i,
  output logic        sdo_o,
  output logic        sdo_oe_o,
  output logic        line_clk_en_o,
  output logic        done_o,
  output logic [2:0]  err_o,
  output logic [1:0]  rid_o,
  output logic [31:0] rdata_o
);
  localparam int M1   = (TIMEOUT_CLKS > PRE_POLL_CLKS) ? TIMEOUT_CLKS : PRE_POLL_CLKS;
  localparam int M2   = (PRIME_CLKS > DRAIN_CLKS) ? PRIME_CLKS : DRAIN_CLKS;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > 64) ? M3 : 64;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int RW   = $clog2(MAX_RETRY + 1);
  localparam int DW   = 32;

  state_e          state;
  logic [CW-1:0]   cnt;
  logic [RW-1:0]   retry;
  logic            rd_q;
  logic [5:0]      nbits;
  logic [2:0]      hdr;
  logic [1:0]      code;
  logic            bit_in;
  logic [3:0]      crc_exp, crc_rcv;

  assign bit_in        = ~sdi_i;
  assign code          = {hdr[0], bit_in};
  assign line_clk_en_o = (state != ST_IDLE);

  slv_rsp_crc4 u_crc (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .init_i(state == ST_HUNT && bit_in),
    .en_i  (state == ST_HDR || state == ST_DATA),
    .bit_i (bit_in), .crc_o (crc_exp)
  );

  slv_rsp_shreg #(.W(DW)) u_data (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state == ST_IDLE && start_i),
    .en_i (state == ST_DATA),
    .bit_i(bit_in), .q_o(rdata_o)
  );

  slv_rsp_shreg #(.W(4)) u_rcrc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state == ST_HUNT && bit_in),
    .en_i (state == ST_CRC),
    .bit_i(bit_in), .q_o(crc_rcv)
  );

  slv_rsp_line_drv #(.POLL_LEN(POLL_LEN), .POLL_WORD(POLL_WORD), .CW(CW)) u_drv (
    .pre_i (state == ST_PRE), .poll_i(state == ST_POLL), .echo_i(state == ST_ECHO),
    .idx_i (cnt), .sdo_o(sdo_o), .oe_o(sdo_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; cnt <= '0; retry <= '0; rd_q <= 1'b0;
      nbits <= 6'd8; hdr <= '0; done_o <= 1'b0; err_o <= '0; rid_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          state <= ST_HUNT; cnt <= '0; retry <= '0; rd_q <= read_i;
          err_o <= ERR_NONE; rid_o <= '0;
          nbits <= (size_i == 2'd0) ? 6'd8 : (size_i == 2'd1) ? 6'd16 : 6'd32;
        end
        ST_HUNT: begin
          if (bit_in) begin state <= ST_HDR; cnt <= '0; end
          else if (cnt == CW'(TIMEOUT_CLKS - 1)) begin state <= ST_DRAIN; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_HDR: begin
          hdr <= {hdr[1:0], bit_in};
          if (cnt == CW'(3)) begin
            rid_o <= hdr[2:1];
            cnt   <= '0;
            unique case (code)
              CODE_ACK:  state <= rd_q ? ST_DATA : ST_CRC;
              CODE_BUSY: if (retry == RW'(MAX_RETRY)) begin
                  state <= ST_IDLE; done_o <= 1'b1; err_o <= ERR_STUCK;
                end else begin
                  state <= ST_PRE; retry <= retry + 1'b1;
                end
              CODE_ERR:  begin state <= ST_TAIL; err_o <= ERR_SLAVE; end
              default:   begin state <= ST_TAIL; err_o <= ERR_SCRC; end
            endcase
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: begin
          if (cnt == CW'(nbits - 6'd1)) begin state <= ST_CRC; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_CRC: begin
          if (cnt == CW'(3)) begin
            cnt <= '0;
            if ({crc_rcv[2:0], bit_in} == crc_exp) state <= ST_PRIME;
            else begin state <= ST_IDLE; done_o <= 1'b1; err_o <= ERR_RCRC; end
          end else cnt <= cnt + 1'b1;
        end
        ST_PRIME: begin
          if (cnt == CW'(PRIME_CLKS - 1)) begin state <= ST_IDLE; done_o <= 1'b1; end
          else cnt <= cnt + 1'b1;
        end
        ST_TAIL: begin
          if (cnt == CW'(TAIL_CLKS - 1)) begin state <= ST_IDLE; done_o <= 1'b1; end
          else cnt <= cnt + 1'b1;
        end
        ST_DRAIN: begin
          if (cnt == CW'(DRAIN_CLKS - 1)) begin
            state <= ST_IDLE; done_o <= 1'b1; err_o <= ERR_TIMEOUT;
          end else cnt <= cnt + 1'b1;
        end
        ST_PRE: begin
          if (cnt == CW'(PRE_POLL_CLKS - 1)) begin state <= ST_POLL; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_POLL: begin
          if (cnt == CW'(POLL_LEN)) begin state <= ST_ECHO; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_ECHO: begin
          if (cnt == CW'(ECHO_CLKS - 1)) begin state <= ST_HUNT; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: completion leaves the bus clock stopped
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !line_clk_en_o);
  // R10: results hold while idle and not restarted
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_clk_en_o && !start_i) |=> ($stable(rdata_o) && $stable(rid_o)));
  // R9: poll count bounded
  p_retry_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry <= RW'(MAX_RETRY));
  // R8: line drive never overlaps completion
  p_oe_no_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> (!done_o && line_clk_en_o));
  // R8: drive window opens with the line high
  p_poll_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> sdo_o);
  // R2: timeout only reported out of the drain phase
  p_timeout_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == ERR_TIMEOUT) |-> $past(state) == ST_DRAIN);
  // R5: mismatch only reported right after the CRC field
  p_rcrc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == ERR_RCRC) |-> $past(state) == ST_CRC);
endmodule

// File: tb/slv_rsp_rx_bench.sv
module slv_rsp_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0, rd = 1'b0, sdi = 1'b1;
  logic [1:0]  size = 2'd0;
  logic        sdo, oe, clk_en, done;
  logic [2:0]  err;
  logic [1:0]  rid;
  logic [31:0] rdata;

  slv_rsp_rx u_slv_rsp_rx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .read_i(rd), .size_i(size),
    .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(oe), .line_clk_en_o(clk_en),
    .done_o(done), .err_o(err), .rid_o(rid), .rdata_o(rdata)
  );

  typedef struct {
    string       tag;
    logic [2:0]  err;
    logic [31:0] data;
    logic [1:0]  id;
    int          lat;
  } exp_t;

  exp_t   q[$];
  int     n_chk = 0, n_fail = 0, polls = 0;
  longint cyc = 0, t0 = 0;
  localparam logic [8:0] POLL_LINE = 9'h1D5;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_crc(input logic [63:0] v, input int n);
    logic [3:0] c;
    logic fb;
    c = 4'h0;
    for (int i = n - 1; i >= 0; i--) begin
      fb = v[i] ^ c[3];
      c = {c[2:0], 1'b0};
      if (fb) c = c ^ 4'h3;
    end
    return c;
  endfunction

  // monitor: pops expected results as completions appear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (q.size() == 0) chk("R6 unexpected done", 64'd1, 64'd0);
        else begin
          e = q.pop_front();
          chk({e.tag, " err"}, 64'(err), 64'(e.err));
          chk({e.tag, " rdata"}, 64'(rdata), 64'(e.data));
          chk({e.tag, " rid"}, 64'(rid), 64'(e.id));
          chk({e.tag, " clk_en at done"}, 64'(clk_en), 64'd0);
          if (e.lat >= 0) chk({e.tag, " latency"}, 64'(cyc - t0), 64'(e.lat));
        end
      end
    end
  end

  // poll frame checker (R8)
  initial begin
    int n;
    logic ok, prev;
    n = 0; ok = 1'b1; prev = 1'b0;
    forever begin
      @(negedge clk);
      if (oe) begin
        if (n < 100)       begin if (sdo !== 1'b1) ok = 1'b0; end
        else if (n == 100) begin if (sdo !== 1'b0) ok = 1'b0; end
        else if (n <= 109) begin if (sdo !== POLL_LINE[109 - n]) ok = 1'b0; end
        else if (sdo !== 1'b1) ok = 1'b0;
        n++;
      end else if (prev) begin
        polls++;
        chk("R8 poll window length", 64'(n), 64'd126);
        chk("R8 poll line pattern", 64'(ok), 64'd1);
        n = 0; ok = 1'b1;
      end
      prev = oe;
    end
  end

  task automatic expect_res(input string tag, input logic [2:0] e, input logic [31:0] d,
                            input logic [1:0] id, input int lat);
    exp_t x;
    x.tag = tag; x.err = e; x.data = d; x.id = id; x.lat = lat;
    q.push_back(x);
  endtask

  task automatic kick(input logic r, input logic [1:0] s);
    @(negedge clk);
    start = 1'b1; rd = r; size = s;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
  endtask

  task automatic send_rsp(input int dly, input logic [1:0] id, input logic [1:0] code,
                          input logic [31:0] data, input int dlen, input bit bad,
                          input bit with_crc);
    logic [63:0] v;
    logic [3:0]  c;
    int n;
    v = 64'd1;
    v = (v << 2) | 64'(id);
    v = (v << 2) | 64'(code);
    v = (v << dlen) | (64'(data) & ((64'd1 << dlen) - 64'd1));
    n = 5 + dlen;
    if (with_crc) begin
      c = ref_crc(v, n);
      if (bad) c = c ^ 4'h1;
      v = (v << 4) | 64'(c);
      n = n + 4;
    end
    for (int i = 0; i < dly; i++) begin sdi = 1'b1; @(negedge clk); end
    for (int i = n - 1; i >= 0; i--) begin sdi = ~v[i]; @(negedge clk); end
    sdi = 1'b1;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_poll();
    while (!oe) @(negedge clk);
    while (oe) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 oe", 64'(oe), 64'd0);
    chk("R1 clk_en", 64'(clk_en), 64'd0);
    chk("R1 err", 64'(err), 64'd0);
    chk("R1 rdata", 64'(rdata), 64'd0);
    chk("R1 rid", 64'(rid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 R3: write ack, no data
    expect_res("R6 write ack", 3'd0, 32'h0, 2'd2, 3 + 109);
    kick(1'b0, 2'd2);
    chk("R10 clk_en running", 64'(clk_en), 64'd1);
    send_rsp(3, 2'd2, 2'd0, 32'h0, 0, 1'b0, 1'b1);
    wait_done();

    // R4: byte read
    expect_res("R4 byte read", 3'd0, 32'h0000_00A5, 2'd1, 0 + 109 + 8);
    kick(1'b1, 2'd0);
    send_rsp(0, 2'd1, 2'd0, 32'hA5, 8, 1'b0, 1'b1);
    wait_done();

    // R4 R3: half-word read, ID 3
    expect_res("R4 half read", 3'd0, 32'h0000_BEEF, 2'd3, 7 + 109 + 16);
    kick(1'b1, 2'd1);
    send_rsp(7, 2'd3, 2'd0, 32'hBEEF, 16, 1'b0, 1'b1);
    wait_done();

    // R4: word read, then R10 hold
    expect_res("R4 word read", 3'd0, 32'hDEAD_BEEF, 2'd0, 2 + 109 + 32);
    kick(1'b1, 2'd2);
    send_rsp(2, 2'd0, 2'd0, 32'hDEAD_BEEF, 32, 1'b0, 1'b1);
    wait_done();
    repeat (10) @(negedge clk);
    chk("R10 rdata held", 64'(rdata), 64'hDEAD_BEEF);
    chk("R10 rid held", 64'(rid), 64'd0);
    chk("R10 clk_en idle", 64'(clk_en), 64'd0);

    // R4: size code 3 is a word
    expect_res("R4 size3 read", 3'd0, 32'h1234_5678, 2'd2, 1 + 109 + 32);
    kick(1'b1, 2'd3);
    send_rsp(1, 2'd2, 2'd0, 32'h1234_5678, 32, 1'b0, 1'b1);
    wait_done();

    // R5: response CRC mismatch
    expect_res("R5 crc mismatch", 3'd5, 32'h0000_003C, 2'd1, 4 + 9 + 8);
    kick(1'b1, 2'd0);
    send_rsp(4, 2'd1, 2'd0, 32'h3C, 8, 1'b1, 1'b1);
    wait_done();

    // R7: slave error codes
    expect_res("R7 slave error", 3'd3, 32'h0, 2'd2, 5 + 9);
    kick(1'b1, 2'd2);
    send_rsp(5, 2'd2, 2'd2, 32'h0, 0, 1'b0, 1'b1);
    wait_done();
    expect_res("R7 slave crc error", 3'd4, 32'h0, 2'd3, 0 + 9);
    kick(1'b0, 2'd0);
    send_rsp(0, 2'd3, 2'd3, 32'h0, 0, 1'b0, 1'b1);
    wait_done();

    // R2: timeout with drain
    expect_res("R2 timeout", 3'd1, 32'h0, 2'd0, 1020);
    kick(1'b1, 2'd0);
    wait_done();

    // R8: busy retried three times, then ack with data
    polls = 0;
    expect_res("R8 busy then ack", 3'd0, 32'h0000_55AA, 2'd1, -1);
    kick(1'b1, 2'd1);
    for (int k = 0; k < 3; k++) begin
      send_rsp(2, 2'd1, 2'd1, 32'h0, 0, 1'b0, 1'b0);
      wait_poll();
    end
    send_rsp(3, 2'd1, 2'd0, 32'h55AA, 16, 1'b0, 1'b1);
    wait_done();
    chk("R8 poll count", 64'(polls), 64'd3);

    // R9: busy forever
    polls = 0;
    expect_res("R9 busy stuck", 3'd2, 32'h0, 2'd2, -1);
    kick(1'b0, 2'd2);
    for (int k = 0; k <= 100; k++) begin
      send_rsp(1, 2'd2, 2'd1, 32'h0, 0, 1'b0, 1'b0);
      if (k < 100) wait_poll();
    end
    wait_done();
    repeat (5) @(negedge clk);
    chk("R9 polls before stuck", 64'(polls), 64'd100);
    chk("R9 no drive after stuck", 64'(oe), 64'd0);
    chk("R6 queue drained", 64'(q.size()), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule